// File: doc/BRIEF.md
# Associative Memory Pattern Matcher

This block holds a bank of stored patterns. Each pattern has one 15-bit coarse bin for each of six layer slots. A bin is a 3-bit layer field above 12 bits of data. Patterns are loaded one slot at a time through a write port.

During an event, coarse-bin hits arrive at up to one per clock. Each hit is compared with every stored bin in parallel. Every (pattern, slot) pair whose bin equals the hit raises a sticky match bit.

Once the event's hits are in, the host sends a series of six opcodes, one per cycle or spread out. The first opcode acts on slot 5 and the last on slot 0. A COUNT opcode advances a pattern's counter only when that slot matched. A SHIFT opcode advances every counter. A pattern whose counter reaches six is queued. Queued patterns leave as road indices, lowest index first, with at least three cycles between roads and never in a cycle that carries an opcode. The host can clear the counters and run another series, and it starts each event with an init strobe.

Top module: `am_road_finder`

## Requirements
- R1: While reset is asserted and in the cycles after it, `road_valid` is low until a pattern has been queued; reset empties the queue and clears every stored bin, match bit and counter.
- R2: A cycle with `cfg_we` high stores `cfg_bin` into slot `cfg_slot` of pattern `cfg_pat`. A `cfg_slot` value of 6 or 7 writes nothing and leaves every slot of that pattern unchanged.
- R3: A cycle with `hit_valid` high sets the match bit of every (pattern, slot) whose stored 15-bit bin equals `hit_word`. Match bits stay set until `evt_init`, and one hit is accepted on every clock.
- R4: After `evt_init` or `cnt_clear`, successive `op_valid` cycles target slots 5, 4, 3, 2, 1, 0 in that order. Opcodes after the sixth are ignored until the next clear.
- R5: `op_shift` = 0 is COUNT, which adds one to a pattern's counter only if that pattern's match bit for the targeted slot is set. `op_shift` = 1 is SHIFT, which adds one to every counter.
- R6: A pattern is queued when its counter reaches 6. Queued patterns are emitted one at a time on `road_valid`/`road_idx`, the lowest index first, and each queued pattern is emitted exactly once.
- R7: `road_valid` is never high in a cycle where `op_valid` or `evt_init` is high.
- R8: Two rising cycles of `road_valid` are at least 3 clock cycles apart.
- R9: `cnt_clear` zeroes all counters and restarts the opcode order at slot 5. It keeps the match bits and the roads already queued.
- R10: `evt_init` clears all match bits, counters and queued roads, and restarts the opcode order.
- R11: A pattern completed by the opcode sampled at clock edge N is presented on `road_valid` in the cycle that follows edge N, provided that cycle has no opcode or init and the spacing rule allows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Pattern slot write strobe |
| cfg_pat | input | $clog2(NPAT) | Pattern index for the write |
| cfg_slot | input | 3 | Slot index for the write (0..5 valid) |
| cfg_bin | input | 15 | Coarse bin to store: layer in [14:12], data in [11:0] |
| hit_valid | input | 1 | Hit strobe |
| hit_word | input | 15 | Coarse-bin hit, same layout as `cfg_bin` |
| evt_init | input | 1 | Start of event: clear matches, counters and queue |
| cnt_clear | input | 1 | Clear counters and restart the opcode order |
| op_valid | input | 1 | Opcode strobe |
| op_shift | input | 1 | Opcode kind: 0 COUNT, 1 SHIFT |
| road_valid | output | 1 | A road index is presented this cycle |
| road_idx | output | $clog2(NPAT) | Index of the emitted pattern |

## Verification
A hit or an opcode takes effect at the clock edge that samples it. The queue is therefore updated at the edge that samples the sixth opcode, and the first road appears combinationally in the following cycle. Each later road follows no sooner than three cycles after the one before it.

The bench drives inputs just after a rising edge and records `road_valid` at the falling edge, tagged with a cycle count. With this timing it can check that the first road lands exactly one cycle after the last opcode's drive cycle. It also checks the spacing between recorded roads, the absence of roads in cycles that carry an opcode, and the order and number of roads against a model built from the requirements. The model is compared only after an idle drain long enough for a full queue to empty.

// File: rtl/am_pkg.sv
package am_pkg;

    localparam int NLAYER     = 6;
    localparam int LAYER_W    = 3;
    localparam int DATA_W     = 12;
    localparam int BIN_W      = LAYER_W + DATA_W;
    localparam int FULL_CNT   = NLAYER;
    localparam int CNT_W      = $clog2(FULL_CNT + 1);
    localparam int FIRST_SLOT = NLAYER - 1;

    typedef enum logic {
        OP_COUNT = 1'b0,
        OP_SHIFT = 1'b1
    } op_e;

    typedef struct packed {
        logic [LAYER_W-1:0] layer;
        logic [DATA_W-1:0]  data;
    } bin_t;

    typedef struct packed {
        logic               en;
        logic [LAYER_W-1:0] slot;
        op_e                kind;
    } step_t;

    function automatic logic bin_equal(bin_t stored, bin_t probe);
        return (stored.layer == probe.layer) && (stored.data == probe.data);
    endfunction

endpackage

// File: rtl/am_op_seq.sv
module am_op_seq
    import am_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  evt_init,
    input  logic  cnt_clear,
    input  logic  op_valid,
    input  logic  op_shift,
    output step_t step
);

    logic [LAYER_W-1:0] slot_q;
    logic               done_q;

    always_ff @(posedge clk) begin
        if (rst || evt_init || cnt_clear) begin
            slot_q <= LAYER_W'(FIRST_SLOT);
            done_q <= 1'b0;
        end else if (op_valid && !done_q) begin
            if (slot_q == '0) begin
                done_q <= 1'b1;
            end else begin
                slot_q <= slot_q - 1'b1;
            end
        end
    end

    always_comb begin
        step.en   = op_valid && !done_q && !evt_init && !cnt_clear && !rst;
        step.slot = slot_q;
        step.kind = op_shift ? OP_SHIFT : OP_COUNT;
    end

endmodule

// File: rtl/am_pattern_cell.sv
module am_pattern_cell
    import am_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [LAYER_W-1:0] wr_slot,
    input  bin_t               wr_bin,
    input  logic               hit_valid,
    input  bin_t               hit,
    input  logic               evt_init,
    input  logic               cnt_clear,
    input  step_t              step,
    output logic               reach_full
);

    bin_t              bins_q [NLAYER];
    logic [NLAYER-1:0] match_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [NLAYER-1:0] hit_eq;
    logic              advance;

    for (genvar k = 0; k < NLAYER; k++) begin : g_slot
        assign hit_eq[k] = bin_equal(bins_q[k], hit);

        always_ff @(posedge clk) begin
            if (rst) begin
                bins_q[k] <= '0;
            end else if (wr_en && wr_slot == LAYER_W'(k)) begin
                bins_q[k] <= wr_bin;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || evt_init) begin
                match_q[k] <= 1'b0;
            end else if (hit_valid && hit_eq[k]) begin
                match_q[k] <= 1'b1;
            end
        end
    end

    always_comb begin
        advance    = step.en && ((step.kind == OP_SHIFT) || match_q[step.slot]);
        reach_full = advance && (cnt_q == CNT_W'(FULL_CNT - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || evt_init || cnt_clear) begin
            cnt_q <= '0;
        end else if (advance && cnt_q != CNT_W'(FULL_CNT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/am_road_queue.sv
module am_road_queue #(
    parameter  int NPAT     = 8,
    parameter  int ROAD_GAP = 3,
    localparam int PW       = $clog2(NPAT),
    localparam int GW       = $clog2(ROAD_GAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          hold,
    input  logic [NPAT-1:0] set_vec,
    output logic          road_valid,
    output logic [PW-1:0] road_idx
);

    logic [NPAT-1:0] pend_q;
    logic [NPAT-1:0] take;
    logic [GW-1:0]   gap_q;
    logic [PW-1:0]   pick;

    always_comb begin
        pick = '0;
        for (int i = NPAT - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick = PW'(i);
            end
        end
    end

    always_comb begin
        road_valid = (|pend_q) && !hold && (gap_q == '0);
        road_idx   = pick;
        take       = '0;
        if (road_valid) begin
            take[pick] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~take) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (road_valid) begin
            gap_q <= GW'(ROAD_GAP - 1);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

endmodule

// File: rtl/am_road_finder.sv
module am_road_finder
    import am_pkg::*;
#(
    parameter  int NPAT     = 8,
    parameter  int ROAD_GAP = 3,
    localparam int PW       = $clog2(NPAT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [PW-1:0] cfg_pat,
    input  logic [2:0]    cfg_slot,
    input  logic [14:0]   cfg_bin,
    input  logic          hit_valid,
    input  logic [14:0]   hit_word,
    input  logic          evt_init,
    input  logic          cnt_clear,
    input  logic          op_valid,
    input  logic          op_shift,
    output logic          road_valid,
    output logic [PW-1:0] road_idx
);

    step_t           step;
    logic [NPAT-1:0] full_vec;
    bin_t            wr_bin;
    bin_t            hit_bin;

    assign wr_bin  = bin_t'(cfg_bin);
    assign hit_bin = bin_t'(hit_word);

    am_op_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .evt_init  (evt_init),
        .cnt_clear (cnt_clear),
        .op_valid  (op_valid),
        .op_shift  (op_shift),
        .step      (step)
    );

    for (genvar p = 0; p < NPAT; p++) begin : g_pat
        am_pattern_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (cfg_we && cfg_pat == PW'(p)),
            .wr_slot    (cfg_slot),
            .wr_bin     (wr_bin),
            .hit_valid  (hit_valid),
            .hit        (hit_bin),
            .evt_init   (evt_init),
            .cnt_clear  (cnt_clear),
            .step       (step),
            .reach_full (full_vec[p])
        );
    end

    am_road_queue #(
        .NPAT     (NPAT),
        .ROAD_GAP (ROAD_GAP)
    ) u_queue (
        .clk        (clk),
        .rst        (rst),
        .flush      (evt_init),
        .hold       (op_valid || evt_init),
        .set_vec    (full_vec),
        .road_valid (road_valid),
        .road_idx   (road_idx)
    );

endmodule

// File: rtl/am_road_chk.sv
module am_road_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          evt_init,
    input logic          op_valid,
    input logic          road_valid,
    input logic [PW-1:0] road_idx
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !road_valid);

    // R7
    no_road_on_op_chk: assert property (@(posedge clk) disable iff (rst)
        road_valid |-> (!op_valid && !evt_init));

    // R8
    gap_one_chk: assert property (@(posedge clk) disable iff (rst)
        road_valid |=> !road_valid);

    // R8
    gap_two_chk: assert property (@(posedge clk) disable iff (rst)
        road_valid |=> ##1 !road_valid);

    // R10
    init_flush_chk: assert property (@(posedge clk) disable iff (rst)
        evt_init |=> !road_valid);

    // R6
    idx_known_chk: assert property (@(posedge clk) disable iff (rst)
        road_valid |-> !$isunknown(road_idx));

endmodule

bind am_road_finder am_road_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_init   (evt_init),
    .op_valid   (op_valid),
    .road_valid (road_valid),
    .road_idx   (road_idx)
);

// File: tb/tb_am_road_finder.sv
module tb_am_road_finder;

    localparam int CLK_PERIOD = 10;
    localparam int NPAT       = 8;
    localparam int PW         = $clog2(NPAT);
    localparam int NL         = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [PW-1:0] cfg_pat;
    logic [2:0]    cfg_slot;
    logic [14:0]   cfg_bin;
    logic          hit_valid;
    logic [14:0]   hit_word;
    logic          evt_init;
    logic          cnt_clear;
    logic          op_valid;
    logic          op_shift;
    logic          road_valid;
    logic [PW-1:0] road_idx;

    am_road_finder #(.NPAT(NPAT), .ROAD_GAP(3)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pat(cfg_pat),
        .cfg_slot(cfg_slot), .cfg_bin(cfg_bin), .hit_valid(hit_valid),
        .hit_word(hit_word), .evt_init(evt_init), .cnt_clear(cnt_clear),
        .op_valid(op_valid), .op_shift(op_shift),
        .road_valid(road_valid), .road_idx(road_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_op_cyc = 0;

    logic [14:0] bins_m [NPAT][NL];
    bit          match_m [NPAT][NL];
    int          cnt_m [NPAT];
    bit          pend_m [NPAT];
    int          ptr_m;

    int got_idx [64];
    int got_cyc [64];
    int got_n = 0;
    bit mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && road_valid) begin
            // R7: no road alongside an opcode or init
            chk(!op_valid && !evt_init, "R7 road during op/init", 1, 0);
            // R8: spacing
            if (got_n > 0)
                chk(cyc - got_cyc[got_n-1] >= 3, "R8 road spacing", cyc - got_cyc[got_n-1], 3);
            if (got_n < 64) begin
                got_idx[got_n] = int'(road_idx);
                got_cyc[got_n] = cyc;
            end
            got_n++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_pat = '0; cfg_slot = '0; cfg_bin = '0;
        hit_valid = 0; hit_word = '0; evt_init = 0; cnt_clear = 0;
        op_valid = 0; op_shift = 0;
    endtask

    task automatic cfg(input int p, input int s, input logic [14:0] v);
        cfg_we = 1; cfg_pat = PW'(p); cfg_slot = 3'(s); cfg_bin = v;
        tick();
        cfg_we = 0;
        if (s < NL) bins_m[p][s] = v;
    endtask

    task automatic hit(input logic [14:0] v);
        hit_valid = 1; hit_word = v;
        tick();
        hit_valid = 0;
        for (int p = 0; p < NPAT; p++)
            for (int s = 0; s < NL; s++)
                if (bins_m[p][s] == v) match_m[p][s] = 1;
    endtask

    task automatic init_ev();
        evt_init = 1;
        tick();
        evt_init = 0;
        for (int p = 0; p < NPAT; p++) begin
            cnt_m[p] = 0; pend_m[p] = 0;
            for (int s = 0; s < NL; s++) match_m[p][s] = 0;
        end
        ptr_m = NL - 1;
    endtask

    task automatic clr_cnt();
        cnt_clear = 1;
        tick();
        cnt_clear = 0;
        for (int p = 0; p < NPAT; p++) cnt_m[p] = 0;
        ptr_m = NL - 1;
    endtask

    task automatic op(input bit shift);
        op_valid = 1; op_shift = shift;
        last_op_cyc = cyc;
        tick();
        op_valid = 0;
        if (ptr_m >= 0) begin
            for (int p = 0; p < NPAT; p++) begin
                if ((shift || match_m[p][ptr_m]) && cnt_m[p] < 6) begin
                    cnt_m[p]++;
                    if (cnt_m[p] == 6) pend_m[p] = 1;
                end
            end
            ptr_m--;
        end
    endtask

    task automatic hit_all(input int p);
        for (int s = 0; s < NL; s++) hit(bins_m[p][s]);
    endtask

    task automatic drain(input string req, input bit timing);
        int exp_idx [NPAT];
        int exp_n;
        exp_n = 0;
        for (int p = 0; p < NPAT; p++)
            if (pend_m[p]) begin exp_idx[exp_n] = p; exp_n++; end
        repeat (3 * NPAT + 8) tick();
        chk(got_n == exp_n, {req, " road count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got_idx[i] == exp_idx[i], {req, " road order"}, got_idx[i], exp_idx[i]);
        // R11: first road one cycle after the last opcode's drive cycle
        if (timing && exp_n > 0 && got_n > 0)
            chk(got_cyc[0] == last_op_cyc + 1, "R11 first road latency", got_cyc[0], last_op_cyc + 1);
        for (int p = 0; p < NPAT; p++) pend_m[p] = 0;
        got_n = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        for (int p = 0; p < NPAT; p++) begin
            cnt_m[p] = 0; pend_m[p] = 0;
            for (int s = 0; s < NL; s++) begin
                bins_m[p][s] = '0; match_m[p][s] = 0;
            end
        end
        ptr_m = NL - 1;
        repeat (3) tick();
        @(negedge clk);
        // R1: quiet output in reset
        chk(road_valid == 0, "R1 road_valid in reset", road_valid, 0);
        @(posedge clk); #1;
        rst = 0;
        mon_on = 1;
        repeat (4) tick();
        @(negedge clk);
        // R1: quiet output after reset
        chk(road_valid == 0, "R1 road_valid after reset", road_valid, 0);
        @(posedge clk); #1;

        // R2: load all patterns with distinct nonzero bins
        for (int p = 0; p < NPAT; p++)
            for (int s = 0; s < NL; s++)
                cfg(p, s, {3'(s), 12'(p * 40 + s * 7 + 3)});

        // R3 R4 R5 R6 R11: sweep every COUNT/SHIFT mix
        for (int mask = 0; mask < 64; mask++) begin
            init_ev();
            for (int p = 0; p < NPAT; p++)
                for (int s = 0; s < NL; s++)
                    if ((p * 7 + s * 3 + mask) % 4 != 0) hit(bins_m[p][s]);
            for (int k = 0; k < NL; k++) op(mask[k]);
            drain("R5 R6 sweep", 1'b1);
        end

        // R4: opcodes after the sixth are ignored
        init_ev();
        for (int s = 1; s < NL; s++) hit(bins_m[2][s]);
        hit_all(5);
        for (int k = 0; k < NL; k++) op(1'b0);
        for (int k = 0; k < 3; k++) op(1'b1);
        drain("R4 extra ops", 1'b0);

        // R9: cnt_clear restarts the series and keeps match bits
        init_ev();
        hit_all(1);
        for (int s = 0; s < 3; s++) hit(bins_m[3][s]);
        for (int k = 0; k < 3; k++) op(1'b1);
        clr_cnt();
        for (int k = 0; k < 3; k++) op(1'b0);
        for (int k = 0; k < 3; k++) op(1'b1);
        drain("R9 counter clear", 1'b0);

        // R10: init drops queued roads before they leave
        init_ev();
        hit_all(0);
        hit_all(4);
        for (int k = 0; k < NL; k++) op(1'b0);
        op(1'b0);
        init_ev();
        drain("R10 init flush", 1'b0);

        // R2: writes to slots 6 and 7 change nothing
        cfg(6, 6, 15'h7123);
        cfg(6, 7, 15'h0456);
        init_ev();
        hit_all(6);
        for (int k = 0; k < NL; k++) op(1'b0);
        drain("R2 ignored slot", 1'b0);

        // R3: hits on consecutive clocks all register (back-to-back)
        init_ev();
        hit_valid = 1;
        for (int s = 0; s < NL; s++) begin
            hit_word = bins_m[7][s];
            tick();
            match_m[7][s] = 1;
        end
        hit_valid = 0;
        for (int k = 0; k < NL; k++) op(1'b0);
        drain("R3 back-to-back hits", 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule